// File: doc/BRIEF.md
# Push-Pull Output Steering Controller

This block is the digital control core of a two-output gate driver. A single-ended drive request arrives on a pair of pins. One pin is active-low and the other is active-high, so a source of either polarity can be used by tying the unused pin to its active level. The block qualifies that request with an over-temperature input and a latched fault-stop input. It then steers the result to output A, output B or both.

There are two steering modes. In parallel mode both outputs follow the qualified request, so the two output stages can be tied together for more current. In alternating mode an internal pointer sends each new drive pulse to the output that did not get the previous one. This turns a single-ended pulse train into a push-pull pair. Both the pointer and the fault latch change only after the request has stayed off for a minimum off-time, given as a number of clock cycles. A per-output inhibit holds one output low, for example until the opposite power switch has turned off.

All pins are plain level controls with no handshake. Each output is registered and reflects the inputs sampled at the previous rising clock edge.

Top module: `pp_steer_ctrl`

## Requirements
- R1: The qualified request is active exactly when `req_inv_n` is 0, `req_pos` is 1 and `overtemp` is 0. Outputs register it with one cycle of latency.
- R2: While the qualified request is inactive, both `out_a` and `out_b` are 0 in the following cycle.
- R3: With `alt_mode` = 1, at most one output is high. Consecutive pulses that are separated by a qualified off interval go to A and B in turn.
- R4: With `alt_mode` = 0 and no inhibit, `out_a` equals `out_b`, and pulses leave the alternation pointer unchanged.
- R5: The pointer advances only once the request has been off for `OFF_CYCLES` consecutive sampled cycles. After a shorter gap the next pulse goes to the same output as the previous one.
- R6: A high `fault_stop` sampled while the request is active forces both outputs to 0 from the next cycle until the end of that pulse, including after `fault_stop` drops.
- R7: The fault latch clears only after `OFF_CYCLES` consecutive off cycles. A pulse after a shorter gap stays low. `fault_stop` sampled while the request is off has no effect.
- R8: A high `overtemp` forces both outputs to 0 in the next cycle, even in the middle of a pulse.
- R9: A high `inh_a` (`inh_b`) holds `out_a` (`out_b`) at 0 and does not affect the other output. Releasing an inhibit mid-pulse turns the steered output on for the rest of that pulse, and the pointer still advances only once for that pulse.
- R10: During and right after reset both outputs are 0, the fault latch is clear and the pointer selects output A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_inv_n | input | 1 | Active-low drive request |
| req_pos | input | 1 | Active-high drive request |
| alt_mode | input | 1 | 1: alternate A/B, 0: parallel |
| fault_stop | input | 1 | Fault stop, latched while a pulse is active |
| overtemp | input | 1 | Over-temperature, forces outputs off |
| inh_a | input | 1 | Hold output A off |
| inh_b | input | 1 | Hold output B off |
| out_a | output | 1 | Drive output A |
| out_b | output | 1 | Drive output B |

## Verification
Every output effect is due exactly one clock cycle after the inputs that cause it are sampled. The bench therefore changes inputs on a falling edge and reads both outputs on the next falling edge.

State changes take longer. The pointer and the fault latch update on the `OFF_CYCLES`-th rising edge that samples the request as off, so the result is visible on the first pulse launched after that gap. The bench counts its off gaps in cycles and places pulses after gaps of exactly `OFF_CYCLES` and `OFF_CYCLES`-1 cycles, so both sides of that boundary are checked.

// File: rtl/pp_steer_pkg.sv
package pp_steer_pkg;
  // Alternation pointer: which output gets the next pulse.
  typedef enum logic {
    SEL_A = 1'b0,
    SEL_B = 1'b1
  } sel_e;

  localparam int NUM_OUT = 2;
endpackage

// File: rtl/pp_req_gate.sv
// Combines the two polarity inputs and the over-temperature term
// into one qualified drive request.
module pp_req_gate (
  input  logic req_inv_n,
  input  logic req_pos,
  input  logic overtemp,
  output logic drive
);
  always_comb begin
    drive = (~req_inv_n) & req_pos & (~overtemp);
  end
endmodule

// File: rtl/pp_offtime.sv
// Counts consecutive off cycles of the qualified request.
// Emits a one-cycle 'qual' strobe on the edge where the count reaches OFF_CYCLES.
module pp_offtime #(
  parameter int OFF_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drive,
  output logic qual
);
  localparam int CW = $clog2(OFF_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(OFF_CYCLES);
  localparam logic [CW-1:0] LAST  = CW'(OFF_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_comb begin
    qual = (~drive) && (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (drive) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pp_toggle.sv
// Alternation pointer. A pulse marks the pointer as used. It flips on the
// next qualified off interval, but only in alternating mode.
module pp_toggle
  import pp_steer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic drive,
  input  logic alt_mode,
  input  logic qual,
  output sel_e sel
);
  logic used_q;
  sel_e sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= 1'b0;
      sel_q  <= SEL_A;
    end else begin
      if (drive) begin
        used_q <= 1'b1;
      end else if (qual) begin
        used_q <= 1'b0;
        if (used_q && alt_mode) begin
          sel_q <= (sel_q == SEL_A) ? SEL_B : SEL_A;
        end
      end
    end
  end

  assign sel = sel_q;
endmodule

// File: rtl/pp_fault_latch.sv
// Shutdown latch: sets on a fault during a pulse, clears on a qualified off interval.
module pp_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic drive,
  input  logic fault_stop,
  input  logic qual,
  output logic latched
);
  logic lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
    end else if (drive && fault_stop) begin
      lat_q <= 1'b1;
    end else if (qual) begin
      lat_q <= 1'b0;
    end
  end

  assign latched = lat_q;
endmodule

// File: rtl/pp_steer_ctrl.sv
// Top level: request gating, off-time qualifier, pointer, fault latch
// and the registered output stage.
module pp_steer_ctrl
  import pp_steer_pkg::*;
#(
  parameter int OFF_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_inv_n,
  input  logic req_pos,
  input  logic alt_mode,
  input  logic fault_stop,
  input  logic overtemp,
  input  logic inh_a,
  input  logic inh_b,
  output logic out_a,
  output logic out_b
);
  logic drive;
  logic qual;
  logic latched;
  sel_e sel;
  logic [NUM_OUT-1:0] inh_vec;
  logic [NUM_OUT-1:0] out_q;

  pp_req_gate u_gate (
    .req_inv_n (req_inv_n),
    .req_pos   (req_pos),
    .overtemp  (overtemp),
    .drive     (drive)
  );

  pp_offtime #(.OFF_CYCLES(OFF_CYCLES)) u_off (
    .clk   (clk),
    .rst_n (rst_n),
    .drive (drive),
    .qual  (qual)
  );

  pp_toggle u_tog (
    .clk      (clk),
    .rst_n    (rst_n),
    .drive    (drive),
    .alt_mode (alt_mode),
    .qual     (qual),
    .sel      (sel)
  );

  pp_fault_latch u_flt (
    .clk        (clk),
    .rst_n      (rst_n),
    .drive      (drive),
    .fault_stop (fault_stop),
    .qual       (qual),
    .latched    (latched)
  );

  assign inh_vec = {inh_b, inh_a};

  // One registered lane per output. Lane i is steered when parallel,
  // or when the pointer selects it.
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
    logic steered;
    logic on_next;

    always_comb begin
      steered = (~alt_mode) | (sel == sel_e'(i));
      on_next = drive & ~latched & ~fault_stop & steered & ~inh_vec[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q[i] <= 1'b0;
      end else begin
        out_q[i] <= on_next;
      end
    end
  end

  assign out_a = out_q[0];
  assign out_b = out_q[1];
endmodule

// File: rtl/pp_steer_chk.sv
module pp_steer_chk (
  input logic clk,
  input logic rst_n,
  input logic req_inv_n,
  input logic req_pos,
  input logic alt_mode,
  input logic fault_stop,
  input logic overtemp,
  input logic inh_a,
  input logic inh_b,
  input logic out_a,
  input logic out_b
);
  // R2, R8: an inactive request gives both outputs low.
  a_r2_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    (req_inv_n || !req_pos || overtemp) |=> (!out_a && !out_b));

  // R3: alternating mode never drives both outputs.
  a_r3_alt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    alt_mode |=> !(out_a && out_b));

  // R4: parallel mode keeps both outputs equal.
  a_r4_par_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_mode && !inh_a && !inh_b) |=> (out_a == out_b));

  // R6: a fault stop turns off both outputs on the next cycle.
  a_r6_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault_stop |=> (!out_a && !out_b));

  // R9: each inhibit holds its own output low.
  a_r9_inh_a: assert property (@(posedge clk) disable iff (!rst_n)
    inh_a |=> !out_a);
  a_r9_inh_b: assert property (@(posedge clk) disable iff (!rst_n)
    inh_b |=> !out_b);
endmodule

bind pp_steer_ctrl pp_steer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_inv_n  (req_inv_n),
  .req_pos    (req_pos),
  .alt_mode   (alt_mode),
  .fault_stop (fault_stop),
  .overtemp   (overtemp),
  .inh_a      (inh_a),
  .inh_b      (inh_b),
  .out_a      (out_a),
  .out_b      (out_b)
);

// File: tb/sim_pp_steer_ctrl.sv
module sim_pp_steer_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int OFF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_inv_n = 1'b1;
  logic req_pos = 1'b0;
  logic alt_mode = 1'b0;
  logic fault_stop = 1'b0;
  logic overtemp = 1'b0;
  logic inh_a = 1'b0;
  logic inh_b = 1'b0;
  logic out_a;
  logic out_b;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pp_steer_ctrl #(.OFF_CYCLES(OFF)) u0 (
    .clk(clk), .rst_n(rst_n), .req_inv_n(req_inv_n), .req_pos(req_pos),
    .alt_mode(alt_mode), .fault_stop(fault_stop), .overtemp(overtemp),
    .inh_a(inh_a), .inh_b(inh_b), .out_a(out_a), .out_b(out_b)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic ea, input logic eb);
    checks++;
    if (out_a !== ea || out_b !== eb) begin
      failures++;
      $display("FAIL %s: out_a/out_b actual=%b%b expected=%b%b", req, out_a, out_b, ea, eb);
    end
  endtask

  task automatic drv_on();
    req_inv_n = 1'b0;
    req_pos = 1'b1;
  endtask

  task automatic idle(input int k);
    req_inv_n = 1'b1;
    req_pos = 1'b0;
    repeat (k) cyc();
  endtask

  // Apply the request for one cycle, then check the registered result.
  task automatic pulse_chk(input string req, input logic ea, input logic eb);
    drv_on();
    cyc();
    chk(req, ea, eb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) cyc();
    chk("R10 in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    cyc();
    chk("R10 after reset", 1'b0, 1'b0);

    // R1 sweep: every combination of the two request pins and overtemp, parallel mode
    alt_mode = 1'b0;
    for (int i = 0; i < 8; i++) begin
      logic e;
      req_inv_n = i[0];
      req_pos = i[1];
      overtemp = i[2];
      e = ~i[0] & i[1] & ~i[2];
      cyc();
      chk("R1 sweep", e, e);
      overtemp = 1'b0;
      idle(OFF);
    end

    // R3 alternation, starting from pointer A (R10)
    alt_mode = 1'b1;
    idle(OFF);
    pulse_chk("R3 R10 first pulse to A", 1'b1, 1'b0);
    pulse_chk("R3 pulse holds A", 1'b1, 1'b0);
    idle(1);
    chk("R2 off low", 1'b0, 1'b0);
    idle(OFF - 1);
    pulse_chk("R3 second pulse to B", 1'b0, 1'b1);
    idle(OFF);
    pulse_chk("R3 third pulse to A", 1'b1, 1'b0);
    idle(OFF - 1);
    pulse_chk("R5 short gap keeps A", 1'b1, 1'b0);
    idle(OFF);                        // pointer now B

    // R4: parallel pulse leaves pointer alone
    alt_mode = 1'b0;
    pulse_chk("R4 parallel both", 1'b1, 1'b1);
    idle(OFF);
    alt_mode = 1'b1;
    pulse_chk("R4 pointer kept at B", 1'b0, 1'b1);
    idle(OFF);                        // pointer now A

    // R9: inhibits
    inh_a = 1'b1;
    pulse_chk("R9 inh_a blocks A", 1'b0, 1'b0);
    inh_a = 1'b0;
    pulse_chk("R9 release mid pulse", 1'b1, 1'b0);
    idle(OFF);                        // pointer now B, one advance
    inh_a = 1'b1;
    pulse_chk("R9 inh_a leaves B", 1'b0, 1'b1);
    inh_a = 1'b0;
    idle(OFF);                        // pointer now A
    inh_b = 1'b1;
    alt_mode = 1'b0;
    pulse_chk("R9 inh_b parallel", 1'b1, 1'b0);
    inh_b = 1'b0;
    idle(OFF);

    // R6 / R7: fault latch, parallel mode
    pulse_chk("R6 pre-fault", 1'b1, 1'b1);
    fault_stop = 1'b1;
    pulse_chk("R6 fault off", 1'b0, 1'b0);
    fault_stop = 1'b0;
    pulse_chk("R6 latched rest of pulse", 1'b0, 1'b0);
    idle(OFF - 1);
    pulse_chk("R7 short gap stays latched", 1'b0, 1'b0);
    idle(OFF);
    pulse_chk("R7 cleared after off-time", 1'b1, 1'b1);
    idle(OFF);
    fault_stop = 1'b1;
    idle(2);
    fault_stop = 1'b0;
    pulse_chk("R7 fault while off ignored", 1'b1, 1'b1);
    idle(OFF);

    // R8: overtemp mid pulse
    pulse_chk("R8 before overtemp", 1'b1, 1'b1);
    overtemp = 1'b1;
    pulse_chk("R8 overtemp forces low", 1'b0, 1'b0);
    overtemp = 1'b0;
    pulse_chk("R8 recovers", 1'b1, 1'b1);
    idle(OFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule